// File: doc/BRIEF.md
# Multi-carrier sinusoidal PWM gate generator

This block turns a stream of signed sine reference samples into gate commands for a cascaded H-bridge inverter. It has `CELLS` bridges, which gives 2·CELLS+1 output levels. The block holds one comparator for each inverter leg, so there are 2·CELLS legs and 4·CELLS switches. It scales each accepted sample by a modulation index and holds the result. It then compares that result against triangular carriers that it builds itself from a single shared up/down counter.

The carriers are level-shifted. Each one occupies its own band of equal height, and the bands stack from the negative full-scale value up to the positive one. A mode input picks how the carriers are phased:

- all bands in phase;
- the bands above zero inverted against the bands below zero;
- every band inverted against the band next to it;
- a single carrier compared against one offset reference for each band.

A mode change waits for the carrier to return to its minimum, so the gate outputs never see a partial carrier period.

Each leg has an upper gate and a lower gate, and the lower gate is always the inverse of the upper one. The carrier frequency is set by `tick_div`: one carrier period lasts 2·(2^BAND_W − 1)·(tick_div+1) clock cycles. With a 50 MHz clock and BAND_W = 8, a tick_div of 97 gives about 1 kHz, and a tick_div of 9 gives about 10 kHz. At either rate a 50 Hz reference sees many carrier periods in each of its own cycles.

Top module: `spwm_gate_gen`

## Requirements
- R1: On each cycle with `ref_valid` high, the block captures a scaled reference. The sample is first clamped to ±FS, where FS = CELLS·2^BAND_W. The index `mod_index` is unsigned with MI_FRAC fraction bits, so 16384 means 1.0 by default. It is limited to at most 1.0. The scaled value is floor(sample·index / 2^MI_FRAC).
- R2: A shared triangle counter t runs 0,1,…,2^BAND_W−1,…,1,0. It takes one step every tick_div+1 cycles. Band k, for k = 0 … 2·CELLS−1, has its lower edge at LO_k = (k−CELLS)·2^BAND_W. Its carrier is LO_k+t, or LO_k+(2^BAND_W−1−t) when the band is inverted.
- R3: Mode code 0 (all in phase): no band is inverted.
- R4: Mode code 1 (halves opposed): bands k ≥ CELLS, the ones above zero, are inverted.
- R5: Mode code 2 (alternating): bands with odd k are inverted.
- R6: Mode code 3 (single carrier): leg k compares the offset reference (scaled − LO_k) against t. Its gates are identical to those of mode 0.
- R7: Bit k of `gate_hi` is high when the held reference is greater than carrier k. The gate is registered, so it reflects the counter and the held reference of the previous cycle. `gate_lo` is always the bitwise inverse of `gate_hi`.
- R8: The set bits of `gate_hi` are always contiguous from bit 0 upward, forming a thermometer code, in every mode.
- R9: A new `mode_sel` value takes effect only at a carrier boundary, which is the step where t goes from 1 to 0 while counting down. The mode is 0 after reset.
- R10: After reset, and until the first `ref_valid`, `gate_hi` is all zeros and `gate_lo` is all ones.
- R11: With a constant reference strictly inside one band, the upper gates show exactly two transitions in total per carrier period, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | Reference sample strobe |
| ref_sample | input | REF_W | Signed reference sample |
| mod_index | input | MI_W | Modulation index, unsigned, MI_FRAC fraction bits |
| mode_sel | input | 2 | Carrier arrangement code (0..3) |
| tick_div | input | DIV_W | Carrier counter step divider |
| gate_hi | output | 2·CELLS | Upper switch gate of each leg |
| gate_lo | output | 2·CELLS | Lower switch gate of each leg |

## Verification
The hardest case to reach is a mode request that arrives in the middle of a carrier period. The old mode must stay in force until the counter comes back down to zero, and it must be replaced exactly at that step. The stimulus changes `mode_sel` at arbitrary points while a slow ramp crosses every band. A cycle-exact scoreboard then compares each gate vector. That scoreboard has its own counter model and its own band arithmetic. Directed phases with constant references count the edges in each carrier period, and they also exercise the clamp on the index and the clamp on the sample.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic [1:0] {
    MODE_INPHASE  = 2'd0,
    MODE_HALVES   = 2'd1,
    MODE_ALTERN   = 2'd2,
    MODE_ONECAR   = 2'd3
  } mode_e;

  // Lower edge of band k in the signed carrier domain.
  function automatic int band_low(int k, int band, int cells);
    return (k - cells) * band;
  endfunction

  // True when band k runs its triangle mirrored in the given mode.
  function automatic logic band_inverted(mode_e m, int k, int cells);
    case (m)
      MODE_HALVES: return (k >= cells);
      MODE_ALTERN: return (k % 2) == 1;
      default:     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int BAND_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  tick_div,
  output logic [BAND_W-1:0] tri_cnt,
  output logic              tick,
  output logic              period_end
);
  localparam logic [BAND_W-1:0] TOP = '1;

  logic [DIV_W-1:0] div_cnt;
  logic             up;

  assign tick       = (div_cnt >= tick_div);
  assign period_end = tick && !up && (tri_cnt == BAND_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tri_cnt <= '0;
      up      <= 1'b1;
    end else if (tick) begin
      div_cnt <= '0;
      if (up) begin
        tri_cnt <= tri_cnt + BAND_W'(1);
        if (tri_cnt == TOP - BAND_W'(1)) up <= 1'b0;
      end else begin
        tri_cnt <= tri_cnt - BAND_W'(1);
        if (tri_cnt == BAND_W'(1)) up <= 1'b1;
      end
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spwm_ref_scale.sv
module spwm_ref_scale #(
  parameter int REF_W   = 12,
  parameter int MI_W    = 16,
  parameter int MI_FRAC = 14,
  parameter int FS      = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_valid,
  input  logic signed [REF_W-1:0] ref_sample,
  input  logic [MI_W-1:0]         mod_index,
  output logic signed [REF_W-1:0] ref_q,
  output logic                    armed
);
  localparam int PW = REF_W + MI_W + 1;
  localparam logic [MI_W-1:0]         ONE  = MI_W'(1 << MI_FRAC);
  localparam logic signed [REF_W-1:0] FS_P = REF_W'(FS);
  localparam logic signed [REF_W-1:0] FS_N = -FS_P;

  logic signed [REF_W-1:0] ref_c;
  logic [MI_W-1:0]         mi_c;
  logic signed [PW-1:0]    prod_w;
  logic signed [PW-1:0]    shf_w;

  always_comb begin
    if (ref_sample > FS_P)      ref_c = FS_P;
    else if (ref_sample < FS_N) ref_c = FS_N;
    else                        ref_c = ref_sample;
    mi_c = (mod_index > ONE) ? ONE : mod_index;
  end

  assign prod_w = PW'(ref_c) * PW'($signed({1'b0, mi_c}));
  assign shf_w  = prod_w >>> MI_FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      armed <= 1'b0;
    end else if (ref_valid) begin
      ref_q <= shf_w[REF_W-1:0];
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spwm_compare.sv
module spwm_compare
  import spwm_pkg::*;
#(
  parameter int CELLS  = 2,
  parameter int BAND_W = 8,
  parameter int REF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    armed,
  input  logic signed [REF_W-1:0] ref_q,
  input  logic [BAND_W-1:0]       tri_cnt,
  input  mode_e                   mode,
  output logic [2*CELLS-1:0]      gate_hi,
  output logic [2*CELLS-1:0]      gate_lo
);
  localparam int LEGS = 2 * CELLS;
  localparam int BAND = 1 << BAND_W;
  localparam int CW   = REF_W + 1;
  localparam logic [BAND_W-1:0] TOP = '1;

  logic [LEGS-1:0]      hit;
  logic signed [CW-1:0] ref_x;
  logic signed [CW-1:0] tri_s;

  assign ref_x = CW'(ref_q);
  assign tri_s = $signed({{(CW-BAND_W){1'b0}}, tri_cnt});

  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    localparam logic signed [CW-1:0] LO = CW'(band_low(k, BAND, CELLS));
    logic [BAND_W-1:0]    phase;
    logic signed [CW-1:0] carrier;
    logic                 shifted_hit;
    logic                 offset_hit;

    assign phase       = band_inverted(mode, k, CELLS) ? (TOP - tri_cnt) : tri_cnt;
    assign carrier     = LO + $signed({{(CW-BAND_W){1'b0}}, phase});
    assign shifted_hit = ref_x > carrier;
    assign offset_hit  = (ref_x - LO) > tri_s;
    assign hit[k]      = (mode == MODE_ONECAR) ? offset_hit : shifted_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= '0;
      gate_lo <= '1;
    end else if (armed) begin
      gate_hi <= hit;
      gate_lo <= ~hit;
    end else begin
      gate_hi <= '0;
      gate_lo <= '1;
    end
  end
endmodule

// File: rtl/spwm_gate_gen.sv
module spwm_gate_gen
  import spwm_pkg::*;
#(
  parameter int CELLS   = 2,
  parameter int BAND_W  = 8,
  parameter int REF_W   = 12,
  parameter int MI_W    = 16,
  parameter int MI_FRAC = 14,
  parameter int DIV_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_valid,
  input  logic signed [REF_W-1:0] ref_sample,
  input  logic [MI_W-1:0]         mod_index,
  input  logic [1:0]              mode_sel,
  input  logic [DIV_W-1:0]        tick_div,
  output logic [2*CELLS-1:0]      gate_hi,
  output logic [2*CELLS-1:0]      gate_lo
);
  localparam int LEGS = 2 * CELLS;
  localparam int FS   = CELLS * (1 << BAND_W);

  // Named internal events, observed by the bound checker.
  logic [BAND_W-1:0]       tri_cnt;
  logic                    tick;
  logic                    period_end;
  logic                    armed;
  logic signed [REF_W-1:0] ref_q;
  mode_e                   mode_act;

  spwm_carrier #(.BAND_W(BAND_W), .DIV_W(DIV_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .tick_div(tick_div),
    .tri_cnt(tri_cnt), .tick(tick), .period_end(period_end)
  );

  spwm_ref_scale #(.REF_W(REF_W), .MI_W(MI_W), .MI_FRAC(MI_FRAC), .FS(FS)) u_scale (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_sample(ref_sample),
    .mod_index(mod_index), .ref_q(ref_q), .armed(armed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_act <= MODE_INPHASE;
    else if (period_end) mode_act <= mode_e'(mode_sel);
  end

  spwm_compare #(.CELLS(CELLS), .BAND_W(BAND_W), .REF_W(REF_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .armed(armed), .ref_q(ref_q), .tri_cnt(tri_cnt),
    .mode(mode_act), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );
endmodule

// File: rtl/spwm_gate_gen_chk.sv
module spwm_gate_gen_chk #(
  parameter int LEGS   = 4,
  parameter int BAND_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              period_end,
  input logic              armed,
  input logic [1:0]        mode_act,
  input logic [BAND_W-1:0] tri_cnt,
  input logic [LEGS-1:0]   gate_hi,
  input logic [LEGS-1:0]   gate_lo
);
  assert_legs_complement_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo == ~gate_hi);

  assert_idle_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (gate_hi == '0));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(mode_act));

  assert_boundary_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (tri_cnt == '0));

  assert_thermometer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi + LEGS'(1)) & gate_hi) == '0);

  assert_counter_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tri_cnt == $past(tri_cnt) + BAND_W'(1)) || (tri_cnt == $past(tri_cnt) - BAND_W'(1)));

  assert_counter_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tri_cnt));
endmodule

bind spwm_gate_gen spwm_gate_gen_chk #(.LEGS(LEGS), .BAND_W(BAND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .period_end(period_end), .armed(armed),
  .mode_act(mode_act), .tri_cnt(tri_cnt), .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/spwm_gate_gen_test.sv
module spwm_gate_gen_test;
  localparam int CLK_NS  = 10;
  localparam int CELLS   = 2;
  localparam int BAND_W  = 8;
  localparam int REF_W   = 12;
  localparam int MI_W    = 16;
  localparam int MI_FRAC = 14;
  localparam int DIV_W   = 8;
  localparam int LEGS    = 2 * CELLS;
  localparam int BAND    = 1 << BAND_W;
  localparam int FS      = CELLS * BAND;
  localparam int ONE     = 1 << MI_FRAC;
  localparam int PERIOD  = 2 * (BAND - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_valid = 1'b0;
  logic signed [REF_W-1:0] ref_sample = '0;
  logic [MI_W-1:0] mod_index = MI_W'(ONE);
  logic [1:0] mode_sel = 2'd0;
  logic [DIV_W-1:0] tick_div = '0;
  logic [LEGS-1:0] gate_hi, gate_lo;

  int checks = 0;
  int failures = 0;
  string cur_req = "R10";

  spwm_gate_gen #(.CELLS(CELLS), .BAND_W(BAND_W), .REF_W(REF_W), .MI_W(MI_W),
                  .MI_FRAC(MI_FRAC), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_sample(ref_sample),
    .mod_index(mod_index), .mode_sel(mode_sel), .tick_div(tick_div),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #(CLK_NS/2) clk = ~clk;

  // Expected-value arithmetic, restated from the requirements.
  function automatic int scale_ref(int r, int m);
    int rc, mc;
    rc = (r > FS) ? FS : ((r < -FS) ? -FS : r);
    mc = (m > ONE) ? ONE : m;
    return (rc * mc) >>> MI_FRAC;
  endfunction

  function automatic logic [LEGS-1:0] expect_gates(int s, int t, int mode);
    logic [LEGS-1:0] g;
    for (int k = 0; k < LEGS; k++) begin
      int lo, c;
      bit mirror;
      lo = -FS + k * BAND;
      mirror = (mode == 1 && k >= CELLS) || (mode == 2 && (k % 2) == 1);
      c = lo + (mirror ? (BAND - 1 - t) : t);
      g[k] = (mode == 3) ? ((s - lo) > t) : (s > c);
    end
    return g;
  endfunction

  task automatic check(string req, string what, logic [LEGS-1:0] act, logic [LEGS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Scoreboard: the model pushes one expected vector per edge.
  logic [LEGS-1:0] exp_q[$];
  int m_div = 0, m_t = 0, m_mode = 0, m_ref = 0;
  bit m_up = 1'b1, m_armed = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.push_back('0);
      m_div = 0; m_t = 0; m_up = 1'b1; m_mode = 0; m_ref = 0; m_armed = 1'b0;
    end else begin
      bit tk, pe;
      exp_q.push_back(m_armed ? expect_gates(m_ref, m_t, m_mode) : '0);
      tk = (m_div >= int'(tick_div));
      pe = tk && !m_up && (m_t == 1);
      if (tk) begin
        m_div = 0;
        if (m_up) begin m_t++; if (m_t == BAND - 1) m_up = 1'b0; end
        else begin m_t--; if (m_t == 0) m_up = 1'b1; end
      end else m_div++;
      if (pe) m_mode = int'(mode_sel);
      if (ref_valid) begin
        m_ref = scale_ref(int'(ref_sample), int'(mod_index));
        m_armed = 1'b1;
      end
    end
  end

  // Monitor: compares away from the edge; lower gates must mirror upper (R7).
  always @(posedge clk) begin
    #(CLK_NS * 3 / 10);
    if (exp_q.size() > 0) begin
      logic [LEGS-1:0] e;
      e = exp_q.pop_front();
      check(cur_req, "gate_hi", gate_hi, e);
      check("R7", "gate_lo", gate_lo, ~e);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int div);
    @(negedge clk);
    rst_n = 1'b0; ref_valid = 1'b0; tick_div = DIV_W'(div);
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic sweep(string req, int mode, int step);
    cur_req = req;
    mode_sel = 2'(mode);
    mod_index = MI_W'(ONE);
    cycles(PERIOD + 2);
    for (int r = -FS - 40; r <= FS + 40; r += step) begin
      ref_valid = 1'b1; ref_sample = REF_W'(r);
      @(negedge clk);
    end
  endtask

  task automatic count_edges(string req, int mode, int n_cyc);
    logic [LEGS-1:0] prev;
    int edges;
    cur_req = req;
    mode_sel = 2'(mode);
    ref_valid = 1'b1; mod_index = MI_W'(ONE);
    ref_sample = REF_W'(-FS + BAND + 100);
    cycles(2 * n_cyc + 4);
    @(posedge clk); #(CLK_NS * 3 / 10);
    prev = gate_hi; edges = 0;
    for (int i = 0; i < n_cyc; i++) begin
      @(posedge clk); #(CLK_NS * 3 / 10);
      edges += $countones(gate_hi ^ prev);
      prev = gate_hi;
    end
    checks++;
    if (edges != 2) begin
      failures++;
      $display("FAIL %s edges per period actual=%0d expected=2", req, edges);
    end
  endtask

  initial begin
    // R10: idle state before any sample.
    do_reset(0);
    cycles(20);
    check("R10", "idle gate_hi", gate_hi, '0);
    check("R10", "idle gate_lo", gate_lo, '1);

    sweep("R3", 0, 1);
    sweep("R4", 1, 1);
    sweep("R5", 2, 1);
    sweep("R6", 3, 1);

    // R9: mode requests in mid-period, scoreboard follows the boundaries.
    cur_req = "R9";
    for (int j = 0; j < 6; j++) begin
      ref_sample = REF_W'(-300 + j * 110);
      cycles(137 + j * 61);
      mode_sel = 2'((j + 1) % 4);
    end
    cycles(PERIOD);

    // R1: clamps on index and sample.
    cur_req = "R1";
    mode_sel = 2'd0;
    ref_sample = REF_W'(FS + 300); mod_index = '1;
    cycles(PERIOD + 4);
    check("R1", "clamped full scale", gate_hi, '1);
    ref_sample = REF_W'(-FS - 300); mod_index = MI_W'(ONE);
    cycles(4);
    check("R1", "clamped negative", gate_hi, '0);
    ref_sample = REF_W'(FS); mod_index = MI_W'(ONE / 2);
    cycles(PERIOD / 3);
    check("R1", "half index", gate_hi, 4'b0111);
    cycles(PERIOD / 2);
    check("R1", "half index later", gate_hi, 4'b0111);

    // R11: two gate transitions per carrier period in each mode.
    count_edges("R11", 0, PERIOD);
    count_edges("R11", 1, PERIOD);
    count_edges("R11", 2, PERIOD);
    count_edges("R11", 3, PERIOD);

    // R2: divided step rate doubles the period.
    do_reset(1);
    cycles(10);
    check("R10", "idle after reset", gate_hi, '0);
    count_edges("R2", 2, 2 * PERIOD);
    sweep("R2", 1, 3);

    cycles(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule